// File: doc/BRIEF.md
# Partitioned SIMD Packed Adder

This block is a 64-bit adder/subtractor whose single carry chain can be split into independent packed lanes. One operation can treat the two operands as one 64-bit value, two 32-bit values, four 16-bit values or eight 8-bit values. Every lane computes at the same time, and no carry crosses from one lane into the next. The block also performs bitwise AND, OR and XOR, which need no splitting.

The carry chain is built from eight byte slices. Each byte boundary has a mux. At a lane's lowest byte the mux feeds in the lane's start carry: 0 for add, 1 for subtract. At every other byte it passes on the carry from the byte below. Subtraction inverts operand B before it enters the chain. The result and a per-byte carry vector are captured in an optional output register, which is present by default.

Top module: `simd_packed_adder`

## Requirements
- R1: `lane_sz` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 16-bit, 2'b10 32-bit and 2'b11 one 64-bit lane. Byte boundary k (1..7) is cut exactly when k is a multiple of the lane width in bytes.
- R2: With `op_sel` = 3'b000 (add), each lane of `result` equals the sum of the matching fields of `op_a` and `op_b`, modulo 2 to the lane width.
- R3: With `op_sel` = 3'b001 (subtract), each lane equals `op_a` field minus `op_b` field, modulo 2 to the lane width. B is inverted and a carry-in of 1 enters only the lowest byte of each lane.
- R4: No carry passes between lanes. All-ones plus one in every lane gives zero in every lane, and nothing spills into the next lane.
- R5: AND (3'b010), OR (3'b011) and XOR (3'b100) give the bitwise result of the operands for every value of `lane_sz`.
- R6: Any other `op_sel` code gives a `result` of zero and a `carry_vec` of zero.
- R7: For add and subtract, `carry_vec[k]` is the carry leaving byte k inside its lane. Bit 8k+7 is that carry, so a lane's top-byte entry is the lane carry-out; for subtract, 1 means no borrow. For logical and unsupported operations, `carry_vec` is all zeros.
- R8: With `REG_OUT` = 1 (the default), outputs change one clock edge after the inputs. A synchronous active-low reset clears `result` and `carry_vec` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | Packed operand A |
| op_b | input | 64 | Packed operand B |
| lane_sz | input | 2 | Lane width code |
| op_sel | input | 3 | Operation select |
| result | output | 64 | Packed result |
| carry_vec | output | 8 | Carry leaving each byte position |

## Verification
A boundary mux that is stuck or decoded wrongly shows up as a lane sum that is off by one in its low bit, or as a wrong top-byte carry. This happens on the very next registered result, but only for operands that make a carry cross that boundary. The bench therefore drives all-ones plus one and 0x80 patterns that place a carry at each lane edge. A bad start-carry injection corrupts every subtraction immediately. A wrong B inversion corrupts it as well. Random operands in each lane mode cover the internal byte carries.

// File: rtl/spa_pkg.sv
// Package for the partitioned packed adder.
// Holds the byte width and the operation and lane-size codes.
// Assumes a byte-sliced datapath throughout.
package spa_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100
    } op_e;

    typedef enum logic [1:0] {
        LANE_8  = 2'b00,
        LANE_16 = 2'b01,
        LANE_32 = 2'b10,
        LANE_64 = 2'b11
    } lane_e;
endpackage

// File: rtl/spa_lane_ctl.sv
// Lane boundary decoder.
// Marks each byte that starts a new lane for the given lane-size code.
// Assumes NBYTES is a power of two of at least 8, so every code is legal.
module spa_lane_ctl #(
    parameter int NBYTES = 8
) (
    input  logic [1:0]        lane_sz,
    output logic [NBYTES-1:0] seg_start
);
    // Decode: byte k starts a lane when k is a multiple of the lane width in bytes.
    always_comb begin
        for (int k = 0; k < NBYTES; k++) begin
            seg_start[k] = ((k % (1 << lane_sz)) == 0);
        end
    end

    // Check that byte 0 always starts a lane and that the number of starts matches the mode.
    always_comb begin
        assert_byte0_start_R1: assert (seg_start[0] == 1'b1);
        assert_start_count_R1: assert ($countones(seg_start) == (NBYTES >> lane_sz));
    end
endmodule

// File: rtl/spa_byte_slice.sv
// One byte slice of the shared carry chain.
// Adds two bytes and a carry-in, and returns the sum and the carry-out.
// Assumes B has already been inverted for subtraction.
module spa_byte_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    // Ripple sum of the slice, with the carry in the extra top bit.
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/simd_packed_adder.sv
// Partitioned SIMD packed adder/subtractor with bitwise operations.
// A mux at every byte boundary cuts the one carry chain into 1, 2, 4 or 8 lanes.
// Assumes NBYTES = 8 (a 64-bit word). REG_OUT adds one register stage with a synchronous active-low reset.
module simd_packed_adder
    import spa_pkg::*;
#(
    parameter int NBYTES  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NBYTES*BYTE_W-1:0] op_a,
    input  logic [NBYTES*BYTE_W-1:0] op_b,
    input  logic [1:0]               lane_sz,
    input  logic [2:0]               op_sel,
    output logic [NBYTES*BYTE_W-1:0] result,
    output logic [NBYTES-1:0]        carry_vec
);
    localparam int DW = NBYTES * BYTE_W;

    logic              is_sub;
    logic              is_arith;
    logic [DW-1:0]     b_eff;
    logic [DW-1:0]     sum_w;
    logic [NBYTES-1:0] seg_start;
    logic [NBYTES-1:0] byte_cin;
    logic [NBYTES-1:0] byte_cout;
    logic [DW-1:0]     nxt_res;
    logic [NBYTES-1:0] nxt_cv;

    // Decode the operation class and invert B for subtraction.
    always_comb begin
        is_sub   = (op_sel == OP_SUB);
        is_arith = (op_sel == OP_ADD) || is_sub;
        b_eff    = is_sub ? ~op_b : op_b;
    end

    spa_lane_ctl #(.NBYTES(NBYTES)) i_lane_ctl (
        .lane_sz  (lane_sz),
        .seg_start(seg_start)
    );

    genvar k;
    generate
        for (k = 0; k < NBYTES; k++) begin : g_byte
            // Boundary mux: at a lane start use the start carry, otherwise the carry from the byte below.
            if (k == 0) begin : g_first
                assign byte_cin[k] = is_sub;
            end else begin : g_link
                assign byte_cin[k] = seg_start[k] ? is_sub : byte_cout[k-1];
            end

            spa_byte_slice #(.W(BYTE_W)) i_slice (
                .a   (op_a[k*BYTE_W +: BYTE_W]),
                .b   (b_eff[k*BYTE_W +: BYTE_W]),
                .cin (byte_cin[k]),
                .sum (sum_w[k*BYTE_W +: BYTE_W]),
                .cout(byte_cout[k])
            );

            // In 8-bit add mode each byte must equal a separate byte add of its fields.
            always_comb begin
                if (lane_sz == LANE_8 && op_sel == OP_ADD) begin
                    assert_lane_sum_R2: assert (sum_w[k*BYTE_W +: BYTE_W] ==
                        BYTE_W'(op_a[k*BYTE_W +: BYTE_W] + op_b[k*BYTE_W +: BYTE_W]));
                end
            end
        end
    endgenerate

    // Select the result and the carry vector for the requested operation.
    always_comb begin
        nxt_cv = '0;
        case (op_sel)
            OP_ADD, OP_SUB: begin
                nxt_res = sum_w;
                nxt_cv  = byte_cout;
            end
            OP_AND:  nxt_res = op_a & op_b;
            OP_OR:   nxt_res = op_a | op_b;
            OP_XOR:  nxt_res = op_a ^ op_b;
            default: nxt_res = '0;
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            // Output register with a synchronous active-low clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    result    <= '0;
                    carry_vec <= '0;
                end else begin
                    result    <= nxt_res;
                    carry_vec <= nxt_cv;
                end
            end

            assert_logic_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(is_arith)) |-> (carry_vec == '0));
            assert_bad_op_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(op_sel) > OP_XOR) |-> (result == '0));
            assert_and_lane_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(op_sel) == OP_AND) |-> (result == $past(op_a & op_b)));
        end else begin : g_comb
            assign result    = nxt_res;
            assign carry_vec = nxt_cv;
        end
    endgenerate
endmodule

// File: tb/test_simd_packed_adder.sv
// Directed bench: one task per scenario, checked against a lane-loop reference model.
module test_simd_packed_adder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  lane_sz = '0;
    logic [2:0]  op_sel = '0;
    logic [63:0] result;
    logic [7:0]  carry_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_packed_adder i_simd_packed_adder (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .lane_sz(lane_sz), .op_sel(op_sel), .result(result), .carry_vec(carry_vec)
    );

    // Reference: loop over the lanes and compute each one as an independent wide add.
    task automatic ref_model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] lz,
                             input logic [2:0] op, output logic [63:0] r, output logic [7:0] cv);
        int lb = 1 << lz;
        r  = '0;
        cv = '0;
        if (op == 3'b010) r = a & b;
        else if (op == 3'b011) r = a | b;
        else if (op == 3'b100) r = a ^ b;
        else if (op <= 3'b001) begin
            for (int lo = 0; lo < 8; lo += lb) begin
                logic [65:0] af = '0;
                logic [65:0] bf = '0;
                logic [65:0] cin = {65'd0, op[0]};
                logic [65:0] tmp;
                for (int j = 0; j < lb; j++) begin
                    af[8*j +: 8] = a[8*(lo+j) +: 8];
                    bf[8*j +: 8] = op[0] ? ~b[8*(lo+j) +: 8] : b[8*(lo+j) +: 8];
                end
                for (int j = 0; j < lb; j++) begin
                    logic [65:0] m = (66'd1 << (8*(j+1))) - 66'd1;
                    tmp = (af & m) + (bf & m) + cin;
                    cv[lo+j] = tmp[8*(j+1)];
                    r[8*(lo+j) +: 8] = tmp[8*j +: 8];
                end
            end
        end
    endtask

    // Apply one operation at a falling edge, then compare at the next falling edge.
    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] lz,
                         input logic [2:0] op, input string req);
        logic [63:0] er;
        logic [7:0]  ec;
        ref_model(a, b, lz, op, er, ec);
        @(negedge clk);
        op_a = a; op_b = b; lane_sz = lz; op_sel = op;
        @(negedge clk);
        n_cmp++;
        if (result !== er) begin
            n_bad++;
            $display("FAIL %s result lz=%0d op=%0d: got %h expected %h", req, lz, op, result, er);
        end
        n_cmp++;
        if (carry_vec !== ec) begin
            n_bad++;
            $display("FAIL %s carry lz=%0d op=%0d: got %b expected %b", req, lz, op, carry_vec, ec);
        end
    endtask

    // R8: reset clears the outputs; outputs change only at the clock edge.
    task automatic t_reset_latency();
        rst_n = 1'b0;
        op_a = '1; op_b = '1; op_sel = 3'b011;
        repeat (2) @(negedge clk);
        n_cmp++;
        if (result !== '0 || carry_vec !== '0) begin
            n_bad++;
            $display("FAIL R8 reset: got %h/%b expected 0/0", result, carry_vec);
        end
        rst_n = 1'b1;
        op_a = 64'h1; op_b = 64'h2; op_sel = 3'b000; lane_sz = 2'b11;
        #1;
        n_cmp++;
        if (result !== '0) begin
            n_bad++;
            $display("FAIL R8 latency: got %h expected 0 before edge", result);
        end
        @(negedge clk);
        n_cmp++;
        if (result !== 64'h3) begin
            n_bad++;
            $display("FAIL R8 latency: got %h expected 3 after edge", result);
        end
    endtask

    // R1 R2 R7: random adds in every lane mode.
    task automatic t_random_add();
        for (int lz = 0; lz < 4; lz++)
            for (int i = 0; i < 20; i++)
                apply({$urandom, $urandom}, {$urandom, $urandom}, 2'(lz), 3'b000, "R2");
    endtask

    // R3 R7: random subtracts in every lane mode, plus equal operands.
    task automatic t_random_sub();
        for (int lz = 0; lz < 4; lz++) begin
            for (int i = 0; i < 20; i++)
                apply({$urandom, $urandom}, {$urandom, $urandom}, 2'(lz), 3'b001, "R3");
            apply(64'h0123_4567_89ab_cdef, 64'h0123_4567_89ab_cdef, 2'(lz), 3'b001, "R3");
            apply(64'h0, 64'h0101_0101_0101_0101, 2'(lz), 3'b001, "R3");
        end
    endtask

    // R4 R1: all-ones plus one in each lane must wrap to zero with no spill between lanes.
    task automatic t_all_ones_plus_one();
        for (int lz = 0; lz < 4; lz++) begin
            logic [63:0] one_per_lane = '0;
            for (int lo = 0; lo < 8; lo += (1 << lz)) one_per_lane[8*lo] = 1'b1;
            apply('1, one_per_lane, 2'(lz), 3'b000, "R4");
        end
    endtask

    // R4 R7: 0x80 patterns put a carry exactly at every lane edge.
    task automatic t_edge_80();
        for (int lz = 0; lz < 4; lz++) begin
            apply(64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 2'(lz), 3'b000, "R4");
            apply(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 2'(lz), 3'b000, "R4");
            apply(64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 2'(lz), 3'b000, "R4");
            apply(64'h7f7f_7f7f_7f7f_7f7f, 64'h8080_8080_8080_8080, 2'(lz), 3'b001, "R3");
        end
    endtask

    // R5: logical ops give the same bitwise result in every lane mode.
    task automatic t_logic();
        for (int lz = 0; lz < 4; lz++)
            for (int op = 2; op <= 4; op++)
                apply(64'hf0f0_1234_ffff_0000, 64'h0ff0_8765_00ff_ffff, 2'(lz), 3'(op), "R5");
    endtask

    // R6: unsupported codes give zero result and zero carries.
    task automatic t_bad_op();
        for (int op = 5; op <= 7; op++)
            apply('1, '1, 2'b00, 3'(op), "R6");
    endtask

    initial begin
        t_reset_latency();
        t_random_add();
        t_random_sub();
        t_all_ones_plus_one();
        t_edge_80();
        t_logic();
        t_bad_op();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule